// File: doc/BRIEF.md
# Floating-Point Condition and Trap Status Register

This block keeps the 32-bit control and status word of a floating-point unit. Eight single-bit condition flags sit inside that word. A compare unit sets one of them through a narrow write port. A branch unit reads one of them back through a 3-bit select. Software may overwrite the whole word through a full-width load strobe. Flag 0 is stored apart from flags 1 to 7. Flag 0 lives at bit 23. Flag n, for n from 1 to 7, lives at bit 24+n. A neighbour that decodes the word depends on these positions.

The block also watches the trap fields without pause and raises a registered trap request. The request goes high when the unimplemented-operation cause (bit 17) is set. It also goes high when any of the five cause bits 16:12 has its matching enable bit among 11:7 set. Cause bit 12+i pairs with enable bit 7+i. The unimplemented-operation cause has no enable bit and cannot be masked.

Every pin is a plain level or a one-cycle strobe, with no valid/ready handshake. The block accepts a write on any cycle and never stalls, so it has no back-pressure to express. Reset is synchronous and active low.

Top module: `fcc_csr_top`

## Requirements
- R1: Condition flag 0 is written to, and read from, bit 23 of the status word.
- R2: Condition flag n, for n from 1 to 7, is written to, and read from, bit 24+n of the status word.
- R3: A flag write changes only the selected bit, on the next rising edge; all other 31 bits keep their values.
- R4: `cc_rdata` shows, with no clock delay, the bit of the current word chosen by `cc_rsel`, for every select value from 0 to 7.
- R5: A full-word load replaces all 32 bits with `word_wdata` on the next rising edge.
- R6: When a full-word load and a flag write fall in the same cycle, the selected flag bit takes `cc_wval`, and every other bit takes `word_wdata`.
- R7: Bit 17 set in the word raises `exc_req`, whatever the enable bits 11:7 hold.
- R8: Bit 17 clear means `exc_req` is high exactly when some cause bit 12+i and its enable bit 7+i, for i from 0 to 4, are both set.
- R9: `exc_req` follows the word with one cycle of lag: it reflects the word held before the most recent rising edge.
- R10: After reset the word is zero, `exc_req` is low and `cc_rdata` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_we | input | 1 | Full-word load strobe |
| word_wdata | input | 32 | Word to load |
| cc_we | input | 1 | Single-flag write strobe |
| cc_wsel | input | 3 | Number of the flag to write |
| cc_wval | input | 1 | Value of the flag to write |
| cc_rsel | input | 3 | Number of the flag to read |
| cc_rdata | output | 1 | Selected flag, combinational |
| exc_req | output | 1 | Registered trap request |
| csr_q | output | 32 | Current status word |

## Verification
The bench builds the block with its default parameters: a 32-bit word and eight flags. With that size the flag sweep is complete. Every write select and value is tried over three background words, and after each write all eight read selects are checked. The trap sweep covers all 1024 pairings of the five cause bits and the five enable bits, with the unimplemented-operation bit both clear and set. Directed sequences cover three cases: a full-word load and a flag write landing together, the one-cycle lag of the trap request as it rises, and the same lag as it falls.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int unsigned CSR_W       = 32;
  localparam int unsigned POS_W       = $clog2(CSR_W);
  localparam int unsigned CC_CNT      = 8;
  localparam int unsigned CC_SEL_W    = $clog2(CC_CNT);
  localparam int unsigned CC0_BIT     = 23;
  localparam int unsigned CC_HI_BASE  = 24;
  localparam int unsigned UNIMP_BIT   = 17;
  localparam int unsigned CAUSE_LO    = 12;
  localparam int unsigned ENABLE_LO   = 7;
  localparam int unsigned TRAP_FIELDS = 5;

  typedef logic [CSR_W-1:0] csr_t;

  // Map a flag number to its bit position in the status word
  function automatic logic [POS_W-1:0] cc_pos(input logic [CC_SEL_W-1:0] sel);
    if (sel == '0) return POS_W'(CC0_BIT);
    return POS_W'(CC_HI_BASE + 32'(sel));
  endfunction

  // One-hot mask of the word bit that a flag number selects
  function automatic csr_t cc_onehot(input logic [CC_SEL_W-1:0] sel);
    csr_t m;
    m = '0;
    for (int k = 0; k < CC_CNT; k++)
      if (sel == CC_SEL_W'(k)) m[cc_pos(CC_SEL_W'(k))] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcc_word_reg.sv
module fcc_word_reg
  import fcc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_we,
  input  csr_t                word_wdata,
  input  logic                cc_we,
  input  logic [CC_SEL_W-1:0] cc_wsel,
  input  logic                cc_wval,
  output csr_t                q
);
  csr_t hit_mask;
  csr_t base;
  csr_t nxt;

  always_comb begin
    hit_mask = cc_we ? cc_onehot(cc_wsel) : '0;
    base     = word_we ? word_wdata : q;
    // flag write overrides the word load on its own bit only
    nxt      = (base & ~hit_mask) | (hit_mask & {CSR_W{cc_wval}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_CC_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |=> q[cc_pos($past(cc_wsel))] == $past(cc_wval)); // R1
  AST_CC_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && !word_we) |=> $countones(q ^ $past(q)) <= 1); // R3
  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && !cc_we) |=> q == $past(word_wdata)); // R5
  AST_WORD_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && cc_we) |=> ((q ^ $past(word_wdata)) & ~cc_onehot($past(cc_wsel))) == '0); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && !cc_we) |=> $stable(q)); // R3
endmodule

// File: rtl/fcc_cc_mux.sv
module fcc_cc_mux
  import fcc_pkg::*;
(
  input  logic [CC_CNT-1:0]   cc_vec,
  input  logic [CC_SEL_W-1:0] sel,
  output logic                bit_out
);
  assign bit_out = cc_vec[sel];
endmodule

// File: rtl/fcc_trap_det.sv
module fcc_trap_det
  import fcc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   unimp,
  input  logic [TRAP_FIELDS-1:0] cause,
  input  logic [TRAP_FIELDS-1:0] enable,
  output logic                   req
);
  logic pending;

  assign pending = unimp | (|(cause & enable));

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= pending;
  end

  AST_UNIMP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    unimp |=> req); // R7
  AST_PAIR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause & enable)) |=> req); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!unimp && ((cause & enable) == '0)) |=> !req); // R8
endmodule

// File: rtl/fcc_csr_top.sv
module fcc_csr_top
  import fcc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_we,
  input  logic [CSR_W-1:0]    word_wdata,
  input  logic                cc_we,
  input  logic [CC_SEL_W-1:0] cc_wsel,
  input  logic                cc_wval,
  input  logic [CC_SEL_W-1:0] cc_rsel,
  output logic                cc_rdata,
  output logic                exc_req,
  output logic [CSR_W-1:0]    csr_q
);
  csr_t              word;
  logic [CC_CNT-1:0] cc_vec;

  fcc_word_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_we    (word_we),
    .word_wdata (word_wdata),
    .cc_we      (cc_we),
    .cc_wsel    (cc_wsel),
    .cc_wval    (cc_wval),
    .q          (word)
  );

  for (genvar k = 0; k < CC_CNT; k++) begin : g_cc
    localparam int unsigned P = (k == 0) ? CC0_BIT : CC_HI_BASE + k;
    assign cc_vec[k] = word[P];
  end

  fcc_cc_mux u_mux (
    .cc_vec  (cc_vec),
    .sel     (cc_rsel),
    .bit_out (cc_rdata)
  );

  fcc_trap_det u_trap (
    .clk    (clk),
    .rst_n  (rst_n),
    .unimp  (word[UNIMP_BIT]),
    .cause  (word[CAUSE_LO +: TRAP_FIELDS]),
    .enable (word[ENABLE_LO +: TRAP_FIELDS]),
    .req    (exc_req)
  );

  assign csr_q = word;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (csr_q == '0 && !exc_req)); // R10
endmodule

// File: tb/sim_fcc_csr_top.sv
module sim_fcc_csr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_we;
  logic [31:0] word_wdata;
  logic        cc_we;
  logic [2:0]  cc_wsel;
  logic        cc_wval;
  logic [2:0]  cc_rsel;
  logic        cc_rdata;
  logic        exc_req;
  logic [31:0] csr_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fcc_csr_top u0 (
    .clk(clk), .rst_n(rst_n), .word_we(word_we), .word_wdata(word_wdata),
    .cc_we(cc_we), .cc_wsel(cc_wsel), .cc_wval(cc_wval), .cc_rsel(cc_rsel),
    .cc_rdata(cc_rdata), .exc_req(exc_req), .csr_q(csr_q)
  );

  function automatic int flag_bit(int n);
    return (n == 0) ? 23 : 24 + n;
  endfunction

  function automatic logic trap_of(logic [31:0] r);
    return r[17] || ((r[16:12] & r[11:7]) != 5'd0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_word(logic [31:0] v);
    word_we = 1'b1; word_wdata = v;
    tick();
    word_we = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] bgs [3];
    logic [31:0] exp;
    bgs[0] = 32'h0000_0000; bgs[1] = 32'hFFFF_FFFF; bgs[2] = 32'hA5A5_A5A5;
    rst_n = 1'b0; word_we = 1'b0; word_wdata = '0; cc_we = 1'b0;
    cc_wsel = '0; cc_wval = 1'b0; cc_rsel = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    check("R10", csr_q, 32'h0, "word after reset");
    check("R10", {31'h0, exc_req}, 32'h0, "trap after reset");
    check("R10", {31'h0, cc_rdata}, 32'h0, "flag after reset");

    // R5 full-word loads
    load_word(32'h1357_2468);
    check("R5", csr_q, 32'h1357_2468, "word load");
    load_word(32'hFEDC_0BA9);
    check("R5", csr_q, 32'hFEDC_0BA9, "word load");

    // R1 R2 R3 R4 flag write sweep
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 2; v++) begin
          load_word(bgs[b]);
          cc_we = 1'b1; cc_wsel = 3'(s); cc_wval = v[0];
          tick();
          cc_we = 1'b0;
          exp = bgs[b];
          exp[flag_bit(s)] = v[0];
          check((s == 0) ? "R1/R3" : "R2/R3", csr_q, exp, "flag write");
          for (int r = 0; r < 8; r++) begin
            cc_rsel = 3'(r);
            #1;
            check("R4", {31'h0, cc_rdata}, {31'h0, exp[flag_bit(r)]}, "flag read");
          end
        end

    // R6 same-cycle load and flag write
    for (int s = 0; s < 8; s++) begin
      exp = 32'h5A3C_96E1 ^ (32'h1 << s);
      word_we = 1'b1; word_wdata = exp;
      cc_we = 1'b1; cc_wsel = 3'(s); cc_wval = ~exp[flag_bit(s)];
      tick();
      word_we = 1'b0; cc_we = 1'b0;
      exp[flag_bit(s)] = ~exp[flag_bit(s)];
      check("R6", csr_q, exp, "load with flag write");
    end

    // R9 one-cycle lag, rising then falling
    load_word(32'h0);
    tick();
    load_word(32'h0002_0000);
    check("R9", {31'h0, exc_req}, 32'h0, "trap before lag");
    tick();
    check("R9", {31'h0, exc_req}, 32'h1, "trap after lag");
    load_word(32'h0);
    check("R9", {31'h0, exc_req}, 32'h1, "trap held before lag");
    tick();
    check("R9", {31'h0, exc_req}, 32'h0, "trap cleared after lag");

    // R7 R8 trap sweep
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 32; c++)
        for (int e = 0; e < 32; e++) begin
          exp = (32'(u) << 17) | (32'(c) << 12) | (32'(e) << 7);
          load_word(exp);
          tick();
          check((u == 1) ? "R7" : "R8", {31'h0, exc_req}, {31'h0, trap_of(exp)}, "trap request");
        end

    report();
  end
endmodule